// File: doc/BRIEF.md
# Memory Address/Data Write-Trap Interlock

This block holds the memory address register, the memory data register and the tag bit that goes with each. It decodes the memory-related destination of each instruction and loads those registers. The tags are set from two fixed instruction bits, following a separate rule for each destination kind. Committed starts of a read or a write leave the block as a one-cycle start pulse.

A memory write learns only some cycles after it starts whether it will fault. While that answer is outstanding, any destination that could overwrite the address or data register freezes the pipeline. The freeze holds until the fault pulse arrives. On a clean resolution the held destination completes unchanged. On a fault it is dropped, so the trap handler reads the old register contents.

A read may also be started early, before its instruction commits. Its tag update to the data register is deferred for one cycle. If the instruction is trapped in that cycle, the block raises an abort for the memory cycle and blocks the returning data from the data register.

Top module: `mem_data_interlock`

## Requirements
- R1: After reset, both registers and both tags are zero, and freeze_o, mem_start_o and mem_abort_o are low.
- R2: Destination code 3 (start read) loads the address register from data_i, sets the data tag from tag_b55_i and the address tag from tag_b54_i, and raises mem_start_o with mem_write_o low in the same cycle.
- R3: Destination code 5 (address start-write) loads the address register and its tag from tag_b54_i, leaves the data tag unchanged, and raises mem_start_o with mem_write_o high.
- R4: Destination code 6 (data start-write) loads the data register and sets both tags. Code 1 (plain data) touches only the data register and its tag. Code 2 (plain address) touches only the address register and its tag.
- R5: While a started write is unresolved, a functional destination with no resolve pulse in that cycle drives freeze_o high, and neither register changes.
- R6: A resolve pulse with wr_fault_i low releases the freeze in that same cycle, and the held destination commits.
- R7: A resolve pulse with wr_fault_i high releases the freeze, discards the held destination, and starts no memory cycle; all registers and tags keep their old values.
- R8: In the default conservative mode, every functional destination (any code, including 0) freezes behind an unresolved write. A register-file destination (dest_func_i low) never freezes and never touches this block's registers.
- R9: Destination code 4 (early read) loads the address register and its tag at once. It sets the data tag from tag_b55_i one cycle later, provided instr_abort_i is low in that cycle.
- R10: If instr_abort_i is high in the cycle after an early read starts, mem_abort_o pulses in that cycle. The data tag is not updated, and returning read data does not load the data register.
- R11: Read data (rd_valid_i) loads the data register when a read was started and has neither returned nor been aborted.
- R12: A resolve pulse clears the unresolved-write state, so later destinations proceed without freezing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dest_valid_i | input | 1 | Instruction is in its destination cycle |
| dest_func_i | input | 1 | Destination is functional (1) rather than the register file (0) |
| dest_code_i | input | 3 | Functional destination: 0 other, 1 data, 2 address, 3 start read, 4 early read, 5 address start-write, 6 data start-write |
| data_i | input | DATA_W | Value written by the destination |
| tag_b55_i | input | 1 | Instruction bit 55 (data tag source) |
| tag_b54_i | input | 1 | Instruction bit 54 (address tag source) |
| wr_resolve_i | input | 1 | Pulse: outstanding write has resolved its fault status |
| wr_fault_i | input | 1 | With wr_resolve_i: the write faults |
| instr_abort_i | input | 1 | Instruction that started an early read last cycle is trapped |
| rd_valid_i | input | 1 | Read data returning |
| rd_data_i | input | DATA_W | Returned read data |
| md_o | output | DATA_W | Data register |
| vma_o | output | DATA_W | Address register |
| md_tag_o | output | 1 | Data tag, readable as status |
| vma_tag_o | output | 1 | Address tag, readable as status |
| freeze_o | output | 1 | Pipeline freeze request |
| mem_start_o | output | 1 | Memory cycle start pulse |
| mem_write_o | output | 1 | Started cycle is a write |
| mem_abort_o | output | 1 | Abort the early-started memory cycle |

## Verification
The hardest cases are the fault-taken discard and the deferred early-read tag. Each needs a write already in flight, with the conflicting destination held across several frozen cycles before the resolve pulse lands with the chosen fault flag. The bench first commits an address start-write. It then holds a start-read destination steady through the freeze and applies the resolve pulse with the fault flag set on a later cycle. Finally it confirms that the address, both tags and the start pulse stayed untouched. For the early read, the abort is raised exactly one cycle after the start. Read data is then returned later to show that the data register keeps its earlier value.

// File: rtl/mdi_pkg.sv
package mdi_pkg;
  typedef enum logic [2:0] {
    DST_OTHER    = 3'd0,
    DST_MD       = 3'd1,
    DST_VMA      = 3'd2,
    DST_RD       = 3'd3,
    DST_RD_EARLY = 3'd4,
    DST_VMA_WR   = 3'd5,
    DST_MD_WR    = 3'd6,
    DST_RSVD     = 3'd7
  } dest_e;

  typedef struct packed {
    logic md_we;
    logic vma_we;
    logic md_tag_we;
    logic vma_tag_we;
    logic rd_start;
    logic rd_early;
    logic wr_start;
  } dest_ctl_t;
endpackage

// File: rtl/mdi_dest_decode.sv
module mdi_dest_decode
  import mdi_pkg::*;
(
  input  dest_e     code_i,
  output dest_ctl_t ctl_o,
  output logic      touches_o
);
  always_comb begin
    ctl_o = '0;
    unique case (code_i)
      DST_MD:       begin ctl_o.md_we = 1'b1; ctl_o.md_tag_we = 1'b1; end
      DST_VMA:      begin ctl_o.vma_we = 1'b1; ctl_o.vma_tag_we = 1'b1; end
      DST_RD:       begin
        ctl_o.vma_we = 1'b1; ctl_o.vma_tag_we = 1'b1;
        ctl_o.md_tag_we = 1'b1; ctl_o.rd_start = 1'b1;
      end
      // md tag deferred to commit point
      DST_RD_EARLY: begin
        ctl_o.vma_we = 1'b1; ctl_o.vma_tag_we = 1'b1;
        ctl_o.rd_start = 1'b1; ctl_o.rd_early = 1'b1;
      end
      DST_VMA_WR:   begin
        ctl_o.vma_we = 1'b1; ctl_o.vma_tag_we = 1'b1; ctl_o.wr_start = 1'b1;
      end
      DST_MD_WR:    begin
        ctl_o.md_we = 1'b1; ctl_o.md_tag_we = 1'b1;
        ctl_o.vma_tag_we = 1'b1; ctl_o.wr_start = 1'b1;
      end
      default:      ctl_o = '0;
    endcase
  end

  assign touches_o = ctl_o.md_we | ctl_o.vma_we | ctl_o.md_tag_we | ctl_o.vma_tag_we;
endmodule

// File: rtl/mdi_write_guard.sv
module mdi_write_guard #(
  parameter bit CONSERVATIVE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dest_valid_i,
  input  logic dest_func_i,
  input  logic touches_i,
  input  logic wr_commit_i,
  input  logic resolve_i,
  input  logic fault_i,
  output logic freeze_o,
  output logic inhibit_o
);
  logic pend_q;
  logic hazard;

  generate
    if (CONSERVATIVE) begin : g_any_func
      assign hazard = dest_func_i;
    end else begin : g_exact
      assign hazard = dest_func_i & touches_i;
    end
  endgenerate

  logic conflict;
  assign conflict  = dest_valid_i & hazard & pend_q;
  assign freeze_o  = conflict & ~resolve_i;
  assign inhibit_o = conflict & resolve_i & fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (wr_commit_i) pend_q <= 1'b1;
    else if (resolve_i)   pend_q <= 1'b0;
  end
endmodule

// File: rtl/mdi_early_read.sv
module mdi_early_read (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic early_commit_i,
  input  logic early_tag_i,
  input  logic rd_commit_i,
  input  logic instr_abort_i,
  input  logic rd_valid_i,
  output logic tag_set_o,
  output logic tag_val_o,
  output logic abort_o,
  output logic rd_load_o
);
  logic early_q, live_q;

  assign tag_set_o = early_q & ~instr_abort_i;
  assign abort_o   = early_q & instr_abort_i;
  assign rd_load_o = rd_valid_i & live_q & ~abort_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q   <= 1'b0;
      tag_val_o <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      early_q <= early_commit_i;
      if (early_commit_i) tag_val_o <= early_tag_i;
      if (rd_commit_i)                  live_q <= 1'b1;
      else if (abort_o || rd_valid_i)   live_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_data_interlock.sv
module mem_data_interlock
  import mdi_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter bit          CONSERVATIVE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dest_valid_i,
  input  logic              dest_func_i,
  input  logic [2:0]        dest_code_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tag_b55_i,
  input  logic              tag_b54_i,
  input  logic              wr_resolve_i,
  input  logic              wr_fault_i,
  input  logic              instr_abort_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] md_o,
  output logic [DATA_W-1:0] vma_o,
  output logic              md_tag_o,
  output logic              vma_tag_o,
  output logic              freeze_o,
  output logic              mem_start_o,
  output logic              mem_write_o,
  output logic              mem_abort_o
);
  dest_ctl_t ctl;
  logic      touches, inhibit, commit;
  logic      tag_set, tag_val, rd_load;

  mdi_dest_decode u_dec (
    .code_i    (dest_e'(dest_code_i)),
    .ctl_o     (ctl),
    .touches_o (touches)
  );

  assign commit      = dest_valid_i & dest_func_i & ~freeze_o & ~inhibit;
  assign mem_start_o = commit & (ctl.rd_start | ctl.wr_start);
  assign mem_write_o = commit & ctl.wr_start;

  mdi_write_guard #(.CONSERVATIVE(CONSERVATIVE)) u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dest_valid_i (dest_valid_i),
    .dest_func_i  (dest_func_i),
    .touches_i    (touches),
    .wr_commit_i  (mem_write_o),
    .resolve_i    (wr_resolve_i),
    .fault_i      (wr_fault_i),
    .freeze_o     (freeze_o),
    .inhibit_o    (inhibit)
  );

  mdi_early_read u_early (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .early_commit_i (commit & ctl.rd_early),
    .early_tag_i    (tag_b55_i),
    .rd_commit_i    (commit & ctl.rd_start),
    .instr_abort_i  (instr_abort_i),
    .rd_valid_i     (rd_valid_i),
    .tag_set_o      (tag_set),
    .tag_val_o      (tag_val),
    .abort_o        (mem_abort_o),
    .rd_load_o      (rd_load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      md_o      <= '0;
      vma_o     <= '0;
      md_tag_o  <= 1'b0;
      vma_tag_o <= 1'b0;
    end else begin
      if (commit && ctl.md_we) md_o <= data_i;
      else if (rd_load)        md_o <= rd_data_i;
      if (commit && ctl.vma_we) vma_o <= data_i;
      if (commit && ctl.md_tag_we) md_tag_o <= tag_b55_i;
      else if (tag_set)            md_tag_o <= tag_val;
      if (commit && ctl.vma_tag_we) vma_tag_o <= tag_b54_i;
    end
  end
endmodule

// File: rtl/mdi_interlock_chk.sv
module mdi_interlock_chk #(
  parameter int unsigned DATA_W       = 32,
  parameter bit          CONSERVATIVE = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dest_valid_i,
  input logic              dest_func_i,
  input logic              wr_resolve_i,
  input logic              wr_fault_i,
  input logic [DATA_W-1:0] vma_o,
  input logic              vma_tag_o,
  input logic              freeze_o,
  input logic              mem_start_o,
  input logic              mem_write_o,
  input logic              mem_abort_o
);
  // R5
  freeze_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> !mem_start_o);

  // R5
  freeze_holds_vma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |=> ($stable(vma_o) && $stable(vma_tag_o)));

  // R7
  resolve_ends_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_resolve_i && wr_fault_i) |-> !freeze_o);

  // R8
  regfile_dest_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dest_valid_i && !dest_func_i) |-> !freeze_o);

  // R10
  abort_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_abort_o |-> $past(mem_start_o));

  // R5
  write_then_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CONSERVATIVE && dest_valid_i && dest_func_i && !wr_resolve_i &&
     $past(mem_start_o && mem_write_o)) |-> freeze_o);
endmodule

bind mem_data_interlock mdi_interlock_chk #(
  .DATA_W(DATA_W), .CONSERVATIVE(CONSERVATIVE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dest_valid_i (dest_valid_i),
  .dest_func_i  (dest_func_i),
  .wr_resolve_i (wr_resolve_i),
  .wr_fault_i   (wr_fault_i),
  .vma_o        (vma_o),
  .vma_tag_o    (vma_tag_o),
  .freeze_o     (freeze_o),
  .mem_start_o  (mem_start_o),
  .mem_write_o  (mem_write_o),
  .mem_abort_o  (mem_abort_o)
);

// File: tb/mem_data_interlock_tb.sv
`timescale 1ns/1ps
module mem_data_interlock_tb;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dest_valid, dest_func, b55, b54, resolve, fault, iabort, rd_valid;
  logic [2:0] code;
  logic [DW-1:0] data, rd_data, md, vma;
  logic md_tag, vma_tag, freeze, mstart, mwrite, mabort;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_data_interlock #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dest_valid_i(dest_valid), .dest_func_i(dest_func),
    .dest_code_i(code), .data_i(data), .tag_b55_i(b55), .tag_b54_i(b54),
    .wr_resolve_i(resolve), .wr_fault_i(fault), .instr_abort_i(iabort),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .md_o(md), .vma_o(vma),
    .md_tag_o(md_tag), .vma_tag_o(vma_tag), .freeze_o(freeze),
    .mem_start_o(mstart), .mem_write_o(mwrite), .mem_abort_o(mabort)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    dest_valid = 0; dest_func = 0; code = 0; data = 0; b55 = 0; b54 = 0;
    resolve = 0; fault = 0; iabort = 0; rd_valid = 0; rd_data = 0;
  endtask

  task automatic dest(input logic [2:0] c, input logic [DW-1:0] d, input logic t55, input logic t54);
    idle();
    dest_valid = 1; dest_func = 1; code = c; data = d; b55 = t55; b54 = t54;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 md", md, 0);
    chk("R1 vma", vma, 0);
    chk("R1 tags", {md_tag, vma_tag}, 0);
    chk("R1 strobes", {freeze, mstart, mabort}, 0);
  endtask

  task automatic t_read();
    dest(3, 32'hA0A0_0001, 1, 0); #2;
    chk("R2 start", {mstart, mwrite}, 2'b10);
    tick(); idle();
    chk("R2 vma", vma, 32'hA0A0_0001);
    chk("R2 tags", {md_tag, vma_tag}, 2'b10);
    rd_valid = 1; rd_data = 32'h1111_2222;
    tick(); idle();
    chk("R11 md load", md, 32'h1111_2222);
  endtask

  task automatic t_vma_wr();
    dest(5, 32'hB0B0_0002, 0, 1); #2;
    chk("R3 start", {mstart, mwrite}, 2'b11);
    tick(); idle();
    chk("R3 vma", vma, 32'hB0B0_0002);
    chk("R3 tags", {md_tag, vma_tag}, 2'b11);
    resolve = 1; tick(); idle();
    dest(1, 32'hC0C0_0003, 0, 0); #2;
    chk("R12 no freeze", freeze, 0);
    tick(); idle();
    chk("R4 plain md", md, 32'hC0C0_0003);
    chk("R4 plain md tags", {md_tag, vma_tag}, 2'b01);
  endtask

  task automatic t_md_wr();
    dest(6, 32'hE0E0_0005, 1, 0); tick(); idle();
    chk("R4 md_wr md", md, 32'hE0E0_0005);
    chk("R4 md_wr tags", {md_tag, vma_tag}, 2'b10);
    resolve = 1; tick(); idle();
    dest(2, 32'hF0F0_0006, 0, 1); tick(); idle();
    chk("R4 plain vma", vma, 32'hF0F0_0006);
    chk("R4 plain vma tags", {md_tag, vma_tag}, 2'b11);
  endtask

  task automatic t_freeze_ok();
    dest(5, 32'h0000_0007, 0, 0); tick();
    dest(1, 32'h0000_0008, 0, 1); #2;
    chk("R5 freeze", freeze, 1);
    tick();
    chk("R5 md held", md, 32'hE0E0_0005);
    #1 chk("R5 freeze held", freeze, 1);
    resolve = 1; #2;
    chk("R6 release", freeze, 0);
    tick(); idle();
    chk("R6 md commit", md, 32'h0000_0008);
    chk("R6 md tag", md_tag, 0);
  endtask

  task automatic t_freeze_trap();
    dest(5, 32'h0000_0009, 0, 1); tick();
    dest(3, 32'h0000_000A, 1, 0); #2;
    chk("R5 freeze read", freeze, 1);
    tick();
    resolve = 1; fault = 1; #2;
    chk("R7 release no start", {freeze, mstart}, 2'b00);
    tick(); idle();
    chk("R7 vma old", vma, 32'h0000_0009);
    chk("R7 tags old", {md_tag, vma_tag}, 2'b01);
    dest(2, 32'h0000_000B, 0, 0); #2;
    chk("R12 cleared", freeze, 0);
    tick(); idle();
    chk("R12 vma", vma, 32'h0000_000B);
  endtask

  task automatic t_cons();
    dest(5, 32'h0000_000C, 0, 0); tick();
    dest(0, 32'h0, 0, 0); #2;
    chk("R8 other func freeze", freeze, 1);
    dest_func = 0; code = 1; data = 32'hDEAD_0000; #1;
    chk("R8 regfile no freeze", freeze, 0);
    tick();
    chk("R8 md untouched", md, 32'h0000_0008);
    idle(); resolve = 1; tick(); idle();
  endtask

  task automatic t_early_ok();
    dest(4, 32'h0000_00A1, 1, 1); #2;
    chk("R9 start", mstart, 1);
    tick(); idle();
    chk("R9 vma", vma, 32'h0000_00A1);
    chk("R9 tag deferred", {md_tag, vma_tag}, 2'b01);
    #2 chk("R9 no abort", mabort, 0);
    tick();
    chk("R9 tag commit", md_tag, 1);
    rd_valid = 1; rd_data = 32'h5555_0001; tick(); idle();
    chk("R11 early data", md, 32'h5555_0001);
  endtask

  task automatic t_early_abort();
    dest(1, 32'h0000_00B2, 0, 0); tick();
    dest(4, 32'h0000_00B3, 1, 0); tick(); idle();
    iabort = 1; #2;
    chk("R10 abort", mabort, 1);
    tick(); idle();
    chk("R10 tag kept", md_tag, 0);
    rd_valid = 1; rd_data = 32'h7777_0002; tick(); idle();
    chk("R10 md kept", md, 32'h0000_00B2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    tick();
    t_read();
    t_vma_wr();
    t_md_wr();
    t_freeze_ok();
    t_freeze_trap();
    t_cons();
    t_early_ok();
    t_early_abort();
    finish_run();
  end
endmodule